// File: doc/BRIEF.md
# Falling-Edge Manchester Reply Decoder

This block recovers the data bits of a Manchester-coded reply sent by a low-frequency RFID tag. It sees only the demodulated tag signal, after carrier demodulation, and it uses only the falling edges of that signal. Every clock cycle stands for one carrier period. The block measures the gap between consecutive falling edges and sorts each gap against fixed thresholds, checked from the largest down. Depending on the class of the gap, it adds zero, one or two bits to a receive buffer that holds whole bytes.

A reader controller pulses `start_i` once its own command has been sent. The block then waits for the reply. The first long gap gives the reply latency. A short run of start-of-frame bits is thrown away. Reception stops in one of three ways: the line falls quiet after bits have arrived, the total wait runs out, or too many gaps are too short to be valid. The controller reads the bytes through a combinational read port.

Top module: `lf_manchester_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o`, `err_o` and `ovf_o` are 0 and `bit_len_o` is 0.
- R2: A `start_i` pulse, even during a reception, clears the buffer, the bit count and all flags, and sets `busy_o`. It also sets the internal last-bit state to 1 and the skip state to 1, and loads the start-of-frame discard count with `SOF_RST`.
- R3: A gap of at least `EOF_T` cycles appends no bit. It sets `latency_o` to the gap minus `HALF_T`. The first gap is counted from the start pulse to the moment the edge leaves the two-flop synchroniser, which is one cycle more than the spacing of the input edge from the start pulse.
- R4: The gap classes append bits as follows:
  - a gap of at least `FOUR_T` appends 0 then 1;
  - a gap of at least `THREE_T` appends 0, then appends 1 only if the skip state is 0, and toggles both the last-bit and the skip state;
  - a gap of at least `TWO_T` appends the last-bit state.
  
  As a result, the recovered bits equal the data that follows the start-of-frame ones, whenever the data ends in a 1.
- R5: While the discard count is nonzero, a `TWO_T`-class gap decrements the count and appends nothing. So a reply sent as 1 followed by `SOF_RST` ones and then data yields exactly the data bits.
- R6: Bit n of the reply is stored in byte n/8, at bit 7-(n mod 8), so the first bit is the most significant. `rd_data_o` shows the byte selected by `rd_addr_i`.
- R7: Reception ends with `done_o`=1 and `busy_o`=0 once the time since the last falling edge exceeds `EOF_T` and `bit_len_o` is nonzero. `busy_o` is seen low exactly `EOF_T`+3 cycles after the last input fall. `done_o`, `timeout_o` and `err_o` are never set together.
- R8: If no frame completes, reception ends with `timeout_o`=1 once `WAIT_MAX` cycles have passed since the start pulse. `busy_o` is seen low `WAIT_MAX`+1 cycles after the start pulse ends.
- R9: A gap below `TWO_T` appends nothing and counts as noise. The reception that sees its (`ERR_LIMIT`+1)-th noise gap stops with `err_o`=1. After `ERR_LIMIT` noise gaps, the block is still busy.
- R10: Bits beyond `8*BUF_BYTES` are dropped. In that case `bit_len_o` stops at the capacity, the stored bytes keep the first bits, and `ovf_o` is set and stays set until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per carrier period |
| rst_n | input | 1 | Active-low asynchronous reset |
| demod_i | input | 1 | Demodulated tag signal, asynchronous |
| start_i | input | 1 | One-cycle pulse that begins a reception |
| rd_addr_i | input | AW | Byte index for the read port |
| rd_data_o | output | 8 | Selected buffer byte |
| bit_len_o | output | LW | Number of bits stored |
| latency_o | output | CW | Reply latency in carrier periods |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | Frame ended normally |
| timeout_o | output | 1 | Maximum wait elapsed |
| err_o | output | 1 | Aborted on too many noise gaps |
| ovf_o | output | 1 | Bits dropped at full buffer |

## Verification
The hardest state to reach from the ports is the middle-of-frame behaviour of the three-half-period class. Its output depends on the skip and last-bit state that earlier gaps have left. The bench therefore encodes every data word of one to seven bits that ends in a 1, places the start-of-frame ones in front, and turns the Manchester levels into a train of falling edges. This runs each gap class from each reachable skip state. The abort on the exact noise count and the drop at full capacity are reached with long dedicated runs: one hundred and then one hundred and one short gaps, and a forty-bit reply sent into a thirty-two-bit buffer.

// File: rtl/lf_manchester_rx.sv
module lf_manchester_rx #(
  parameter int HALF_T    = 8,
  parameter int TWO_T     = 12,
  parameter int THREE_T   = 20,
  parameter int FOUR_T    = 28,
  parameter int EOF_T     = 40,
  parameter int WAIT_MAX  = 2000,
  parameter int SOF_RST   = 1,
  parameter int ERR_LIMIT = 100,
  parameter int BUF_BYTES = 4,
  parameter int CW        = 16,
  localparam int NBITS = BUF_BYTES * 8,
  localparam int AW    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LW    = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          demod_i,
  input  logic          start_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [LW-1:0] bit_len_o,
  output logic [CW-1:0] latency_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          err_o,
  output logic          ovf_o
);
  localparam int SW = $clog2(SOF_RST + 2);
  localparam int EW = $clog2(ERR_LIMIT + 2);
  localparam logic [CW-1:0] HALF_C  = CW'(HALF_T);
  localparam logic [CW-1:0] TWO_C   = CW'(TWO_T);
  localparam logic [CW-1:0] THREE_C = CW'(THREE_T);
  localparam logic [CW-1:0] FOUR_C  = CW'(FOUR_T);
  localparam logic [CW-1:0] EOF_C   = CW'(EOF_T);
  localparam logic [CW-1:0] WAIT_C  = CW'(WAIT_MAX);
  localparam logic [SW-1:0] SOF_C   = SW'(SOF_RST);
  localparam logic [EW-1:0] ERR_C   = EW'(ERR_LIMIT);

  logic [2:0]       sync_q;
  logic             fall;
  logic [CW-1:0]    gap_q, wait_q;
  logic [SW-1:0]    sof_q;
  logic [EW-1:0]    errc_q;
  logic             last_q, skip_q;
  logic [NBITS-1:0] bits_q, bits_nxt, rd_win;
  logic [LW-1:0]    len_q;
  logic [1:0]       n_app, n_keep;
  logic             b0, b1;
  logic             is_eof, is4, is3, is2;

  assign fall   = sync_q[2] & ~sync_q[1];
  assign is_eof = gap_q >= EOF_C;
  assign is4    = gap_q >= FOUR_C;
  assign is3    = gap_q >= THREE_C;
  assign is2    = gap_q >= TWO_C;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], demod_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     gap_q <= '0;
    else if (start_i)               gap_q <= '0;
    else if (fall)                  gap_q <= CW'(1);
    else if (gap_q != {CW{1'b1}})   gap_q <= gap_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              wait_q <= '0;
    else if (start_i)                        wait_q <= '0;
    else if (busy_o && wait_q != {CW{1'b1}}) wait_q <= wait_q + 1'b1;

  always_comb begin
    n_app = 2'd0;
    b0    = 1'b0;
    b1    = 1'b1;
    if (is_eof) n_app = 2'd0;
    else if (is4) n_app = 2'd2;
    else if (is3) n_app = skip_q ? 2'd1 : 2'd2;
    else if (is2 && sof_q == '0) begin
      n_app = 2'd1;
      b0    = last_q;
    end
  end

  always_comb begin
    int room;
    room   = NBITS - int'(len_q);
    n_keep = (int'(n_app) > room) ? 2'(room) : n_app;
  end

  always_comb begin
    bits_nxt = bits_q;
    for (int i = 0; i < NBITS; i++) begin
      if (n_keep != 2'd0 && int'(len_q) == i)     bits_nxt[i] = b0;
      if (n_keep == 2'd2 && int'(len_q) + 1 == i) bits_nxt[i] = b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_o <= 1'b0; done_o <= 1'b0; timeout_o <= 1'b0; err_o <= 1'b0; ovf_o <= 1'b0;
      len_q <= '0; bits_q <= '0; last_q <= 1'b1; skip_q <= 1'b1;
      sof_q <= '0; errc_q <= '0; latency_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1; done_o <= 1'b0; timeout_o <= 1'b0; err_o <= 1'b0; ovf_o <= 1'b0;
      len_q <= '0; bits_q <= '0; last_q <= 1'b1; skip_q <= 1'b1;
      sof_q <= SOF_C; errc_q <= '0; latency_o <= '0;
    end else if (busy_o) begin
      if (fall) begin
        bits_q <= bits_nxt;
        len_q  <= len_q + LW'(n_keep);
        if (n_keep != n_app) ovf_o <= 1'b1;
        if (is_eof) latency_o <= gap_q - HALF_C;
        else if (is4) ;
        else if (is3) begin
          last_q <= ~last_q;
          skip_q <= ~skip_q;
        end else if (is2) begin
          if (sof_q != '0) sof_q <= sof_q - 1'b1;
        end else if (errc_q == ERR_C) begin
          busy_o <= 1'b0;
          err_o  <= 1'b1;
        end else errc_q <= errc_q + 1'b1;
      end else if (gap_q > EOF_C && len_q != '0) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (wait_q >= WAIT_C) begin
        busy_o    <= 1'b0;
        timeout_o <= 1'b1;
      end
    end

  assign rd_win    = bits_q >> {rd_addr_i, 3'b000};
  assign bit_len_o = len_q;

  for (genvar j = 0; j < 8; j++) begin : g_rd
    assign rd_data_o[7-j] = rd_win[j];
  end
endmodule

// File: rtl/lf_manchester_rx_chk.sv
module lf_manchester_rx_chk #(
  parameter int LW    = 6,
  parameter int NBITS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          timeout_o,
  input logic          err_o,
  input logic          ovf_o,
  input logic [LW-1:0] bit_len_o
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && bit_len_o == '0 && !done_o && !ovf_o)); // R2
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (int'(bit_len_o) >= int'($past(bit_len_o)) &&
                  int'(bit_len_o) <= int'($past(bit_len_o)) + 2)); // R4
  AST_DONE_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> bit_len_o != '0); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, err_o})); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(bit_len_o)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_len_o) <= NBITS); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !start_i) |=> ovf_o); // R10
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o); // R9
endmodule

bind lf_manchester_rx lf_manchester_rx_chk #(.LW(LW), .NBITS(NBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .timeout_o(timeout_o), .err_o(err_o), .ovf_o(ovf_o), .bit_len_o(bit_len_o)
);

// File: tb/lf_manchester_rx_tb.sv
module lf_manchester_rx_tb_top;
  localparam int HALF_T = 8, EOF_T = 40, WAIT_MAX = 2000, SOF_RST = 1;
  localparam int ERR_LIMIT = 100, BUF_BYTES = 4, NBITS = 32;

  logic clk = 1'b0, rst_n = 1'b0, demod = 1'b1, start = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [5:0]  bit_len;
  logic [15:0] latency;
  logic busy, done, tmo, err, ovf;
  int n_tests = 0, n_fail = 0;
  int tx[64];
  int ntx;

  always #2 clk = ~clk;

  lf_manchester_rx dut_i (
    .clk(clk), .rst_n(rst_n), .demod_i(demod), .start_i(start), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .bit_len_o(bit_len), .latency_o(latency), .busy_o(busy),
    .done_o(done), .timeout_o(tmo), .err_o(err), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // falling input edge n cycles after the previous one (or after the start pulse)
  task automatic edge_in(input int n);
    repeat (n - 1) @(negedge clk);
    demod = 1'b0;
    @(negedge clk) demod = 1'b1;
  endtask

  task automatic rd_byte(input int k, output int v);
    @(negedge clk) rd_addr = 2'(k);
    #1 v = int'(rd_data);
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (busy && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  // tx[0..ntx-1] carries leading one, SOF ones and data; data bits start at index 1+SOF_RST
  task automatic run_frame(input int lat0, input bit check_timing);
    int lvl[128];
    int prev_h, first, c, v, ndata, keep, expb;
    for (int i = 0; i < ntx; i++) begin
      lvl[2*i]   = tx[i];
      lvl[2*i+1] = 1 - tx[i];
    end
    do_start();
    chk(busy && bit_len == 0 && !done && !ovf, "R2 start", int'(bit_len), 0);
    first = 1; prev_h = 0;
    for (int h = 1; h < 2*ntx; h++) begin
      if (lvl[h-1] == 1 && lvl[h] == 0) begin
        if (first != 0) edge_in(lat0);
        else edge_in((h - prev_h) * HALF_T);
        first = 0; prev_h = h;
      end
    end
    wait_idle(c);
    ndata = ntx - 1 - SOF_RST;
    keep  = (ndata > NBITS) ? NBITS : ndata;
    chk(done == 1'b1, "R7 done", int'(done), 1);
    if (check_timing) chk(c == EOF_T + 3, "R7 end time", c, EOF_T + 3);
    chk(int'(latency) == lat0 + 1 - HALF_T, "R3 latency", int'(latency), lat0 + 1 - HALF_T);
    chk(int'(bit_len) == keep, "R5 length", int'(bit_len), keep);
    chk(ovf == (ndata > NBITS), "R10 ovf", int'(ovf), int'(ndata > NBITS));
    for (int k = 0; k < BUF_BYTES; k++) begin
      expb = 0;
      for (int b = 0; b < 8; b++)
        if (8*k + b < keep && tx[1 + SOF_RST + 8*k + b] != 0) expb |= 1 << (7 - b);
      rd_byte(k, v);
      chk(v == expb, "R4 R6 byte", v, expb);
    end
  endtask

  initial begin
    int c, v;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tmo && !err && !ovf && bit_len == 0, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && bit_len == 0, "R1 after release", int'(bit_len), 0);

    // sweep every data word of 1..7 bits ending in 1
    for (int k = 1; k <= 7; k++) begin
      for (int p = 0; p < (1 << (k - 1)); p++) begin
        ntx = 0;
        for (int s = 0; s <= SOF_RST; s++) tx[ntx++] = 1;
        for (int i = 0; i < k - 1; i++) tx[ntx++] = (p >> i) & 1;
        tx[ntx++] = 1;
        run_frame(45 + (p % 5) * 3, 1'b1);
      end
    end

    // overflow: 40 data bits into 32-bit buffer
    ntx = 0;
    for (int s = 0; s <= SOF_RST; s++) tx[ntx++] = 1;
    for (int i = 0; i < 39; i++) tx[ntx++] = (i % 3 == 0) ? 1 : 0;
    tx[ntx++] = 1;
    run_frame(60, 1'b1);
    do_start();
    chk(!ovf, "R10 ovf cleared by start", int'(ovf), 0);

    // restart in mid-reception
    edge_in(50); edge_in(16); edge_in(16);
    repeat (3) @(negedge clk);
    chk(bit_len == 1, "R4 partial", int'(bit_len), 1);
    do_start();
    chk(busy && bit_len == 0, "R2 restart", int'(bit_len), 0);
    rd_byte(0, v);
    chk(v == 0, "R2 buffer cleared", v, 0);

    // timeout with no edges
    do_start();
    wait_idle(c);
    chk(tmo && !done && !err, "R8 timeout flag", int'(tmo), 1);
    chk(c == WAIT_MAX + 1, "R8 timeout cycle", c, WAIT_MAX + 1);

    // noise abort
    do_start();
    for (int i = 0; i < ERR_LIMIT; i++) edge_in(6);
    repeat (3) @(negedge clk);
    chk(busy && !err, "R9 still busy at limit", int'(busy), 1);
    chk(bit_len == 0, "R9 noise appends nothing", int'(bit_len), 0);
    edge_in(6);
    repeat (3) @(negedge clk);
    chk(err && !busy, "R9 abort", int'(err), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule